// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of a programmable serial port. A processor writes characters into a one-entry holding buffer. Each character moves into a separate shift register as soon as that register has nothing left to send. The shift register then puts the character on the serial line. It uses either asynchronous framing (start bit, data, optional parity, stop bits) or synchronous framing (data and optional parity only). In synchronous mode the line is never left empty: whenever no data character is waiting, the configured sync character is sent again and again.

Bit timing comes from a one-cycle pulse, `txclk_fall`, which marks each falling edge of the transmit clock. In asynchronous mode a divider turns 1, 16 or 64 of these pulses into one bit time. In synchronous mode every pulse is one bit. Transmission is allowed only while the command enable is high and clear-to-send is asserted (low). A character already in the shift register is always finished, even when the enable drops during it. Two status outputs, ready and empty, tell the processor when it may write and when the line has drained.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: An asynchronous frame is sent in this order: a 0 start bit; then `cfg_len`+5 data bits, least significant first; then, if `cfg_par_en` is set, a parity bit (even parity when `cfg_par_odd`=0, odd parity when it is 1); then one stop bit of 1, or two when `cfg_stop2`=1.
- R3: In asynchronous mode one bit lasts F transmit-clock fall pulses. F is 1 for `cfg_baud`=00, 16 for 01, and 64 for 1x. F counts from reset. `txd` changes only in a cycle in which `txclk_fall` is high.
- R4: When the shift register is idle and transmission is enabled, a written character moves from the holding buffer into the shift register on the second clock edge after the write cycle. `tx_rdy` is low after the first of those edges and high again after the second.
- R5: `tx_rdy` is low while the holding buffer holds a character. A write while it is low replaces the buffered character, with no error indication. Only the latest character is sent.
- R6: When a character is waiting in the holding buffer, its start bit follows the previous frame's last stop bit on the next bit time, with no idle bit between them.
- R7: `tx_empty` is low while a data character is in the holding buffer or still has bits to send in the shift register. It rises on the bit time in which the last bit of the last data character is driven.
- R8: In synchronous mode (`cfg_sync`=1) each bit lasts one fall pulse. A data character is sent as its data bits (least significant first) plus the optional parity bit, with no start or stop bits. While no data character is waiting, `cfg_sync_char` is sent in the same format without end, and `tx_empty` stays high.
- R9: Transmission is enabled only while `tx_en`=1 and `cts_n`=0. Clearing the enable does not cut short the character in the shift register. While disabled, no character leaves the holding buffer and the idle line stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe for the holding buffer |
| wr_data | input | 8 | Character to transmit |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfg_baud | input | 2 | Async clock factor: 00 x1, 01 x16, 1x x64 |
| cfg_len | input | 2 | Data bits minus 5 (0..3 for 5..8 bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits (async) |
| cfg_sync_char | input | 8 | Fill character for synchronous idle |
| tx_en | input | 1 | Transmit enable from the command word |
| cts_n | input | 1 | Clear to send, active low |
| txclk_fall | input | 1 | One-cycle pulse per transmit-clock falling edge |
| txd | output | 1 | Serial data out |
| tx_rdy | output | 1 | Holding buffer empty, ready for a write |
| tx_empty | output | 1 | No data character left to send |

## Verification
A write sets the buffer at the first edge, so `tx_rdy` falls there. The bench samples it at the falling clock edge after that. The move into an idle shifter happens at the second edge, and the bench checks the restored `tx_rdy` and the low `tx_empty` one negative edge later. A serial bit is registered on the same edge that sees its fall pulse, so the bench samples `txd` at the negative edge that ends each pulse. It keeps its own count of pulses from reset to know which pulses begin a new bit, and it checks that `txd` holds still on all the other pulses.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;
    localparam int NCNT_W  = $clog2(FRAME_W + 1);
    localparam int DIV_W   = 6;

    typedef struct packed {
        logic              sync;
        logic [1:0]        len;
        logic              par_en;
        logic              par_odd;
        logic              stop2;
        logic [DATA_W-1:0] sync_char;
    } txcfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NCNT_W-1:0]  n;
    } frame_t;

    // Build the bit vector to shift out, bit 0 first; unused upper bits are marks.
    function automatic frame_t make_frame(input logic [DATA_W-1:0] d,
                                          input txcfg_t c,
                                          input logic framed);
        frame_t            f;
        logic [NCNT_W-1:0] p;
        logic              par;
        f.bits = '1;
        p      = '0;
        par    = c.par_odd;
        if (framed) begin
            f.bits[p] = 1'b0;
            p = p + 1'b1;
        end
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(c.len) + 5) begin
                f.bits[p] = d[i];
                par = par ^ d[i];
                p = p + 1'b1;
            end
        end
        if (c.par_en) begin
            f.bits[p] = par;
            p = p + 1'b1;
        end
        if (framed) p = p + (c.stop2 ? NCNT_W'(2) : NCNT_W'(1));
        f.n = p;
        return f;
    endfunction

endpackage

// File: rtl/tx_baud.sv
module tx_baud
    import tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] baud_i,
    input  logic       fall_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t         st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        st_d = st_q;
        if (sync_i || baud_i == 2'b00) limit = DIV_W'(0);
        else if (baud_i == 2'b01)      limit = DIV_W'(15);
        else                           limit = DIV_W'(63);
        tick_o = fall_i && (st_q.cnt >= limit);
        if (fall_i) st_d.cnt = tick_o ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    tick_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> fall_i);

endmodule

// File: rtl/tx_hold.sv
module tx_hold
    import tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.full = 1'b1;
            st_d.data = data_i;
        end else if (take_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

    // R5
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> full_o);

    // R5
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !wr_i && !take_i) |=> (full_o && $stable(data_o)));

endmodule

// File: rtl/tx_shift.sv
module tx_shift
    import tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  txcfg_t            cfg_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    output logic              take_o,
    output logic              data_busy_o,
    output logic              txd_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [NCNT_W-1:0]  n;
        logic               is_data;
        logic               txd;
    } sh_st_t;

    sh_st_t st_d, st_q;
    frame_t nf;
    logic   idle;

    always_comb begin
        st_d   = st_q;
        take_o = 1'b0;
        idle   = (st_q.n == '0);
        nf     = '0;
        if (idle && hold_full_i && run_i) begin
            nf         = make_frame(hold_data_i, cfg_i, !cfg_i.sync);
            st_d.frame = nf.bits;
            st_d.n     = nf.n;
            st_d.is_data = 1'b1;
            take_o     = 1'b1;
        end else if (idle && tick_i && cfg_i.sync && run_i) begin
            nf         = make_frame(cfg_i.sync_char, cfg_i, 1'b0);
            st_d.frame = nf.bits;
            st_d.n     = nf.n;
            st_d.is_data = 1'b0;
        end
        if (tick_i) begin
            if (st_d.n != '0) begin
                st_d.txd   = st_d.frame[0];
                st_d.frame = {1'b1, st_d.frame[FRAME_W-1:1]};
                st_d.n     = st_d.n - 1'b1;
            end else begin
                st_d.txd   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame   <= '1;
            st_q.n       <= '0;
            st_q.is_data <= 1'b0;
            st_q.txd     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_busy_o = st_q.is_data && !idle;
    assign txd_o       = st_q.txd;

    // R3
    line_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(txd_o));

    // R9
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !run_i && tick_i) |=> txd_o);

    // R2
    always_comb begin
        count_range_chk: assert (!rst_n || st_q.n <= NCNT_W'(FRAME_W));
    end

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
    import tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cfg_sync,
    input  logic [1:0] cfg_baud,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic [7:0] cfg_sync_char,
    input  logic       tx_en,
    input  logic       cts_n,
    input  logic       txclk_fall,
    output logic       txd,
    output logic       tx_rdy,
    output logic       tx_empty
);

    txcfg_t            cfg;
    logic              run, tick, take, hold_full, data_busy;
    logic [DATA_W-1:0] hold_data;

    always_comb begin
        cfg.sync      = cfg_sync;
        cfg.len       = cfg_len;
        cfg.par_en    = cfg_par_en;
        cfg.par_odd   = cfg_par_odd;
        cfg.stop2     = cfg_stop2;
        cfg.sync_char = cfg_sync_char;
        run           = tx_en && !cts_n;
    end

    tx_baud u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (cfg_sync),
        .baud_i (cfg_baud),
        .fall_i (txclk_fall),
        .tick_o (tick)
    );

    tx_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en),
        .data_i (wr_data),
        .take_i (take),
        .full_o (hold_full),
        .data_o (hold_data)
    );

    tx_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .run_i       (run),
        .tick_i      (tick),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .take_o      (take),
        .data_busy_o (data_busy),
        .txd_o       (txd)
    );

    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && !data_busy;

    // R7
    empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    // R9
    no_take_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !run && !wr_en) |=> hold_full);

endmodule

// File: tb/sim_serial_tx_dbuf.sv
`timescale 1ns/1ps
module sim_serial_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_sync = 1'b0;
    logic [1:0] cfg_baud = 2'b00;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic [7:0] cfg_sync_char = 8'h16;
    logic       tx_en = 1'b1, cts_n = 1'b0, txclk_fall = 1'b0;
    logic       txd, tx_rdy, tx_empty;

    int n_chk = 0, n_bad = 0, pcount = 0, fac = 1;
    logic [127:0] expv;
    int           en;

    always #2 clk = ~clk;

    serial_tx_dbuf u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        txclk_fall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pcount = 0;
        @(negedge clk);
    endtask

    task automatic cfg_async(input logic [1:0] b, input int len, input bit pe,
                             input bit po, input bit s2);
        cfg_sync = 1'b0; cfg_baud = b; cfg_len = 2'(len - 5);
        cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
        fac = (b == 2'b00) ? 1 : (b == 2'b01) ? 16 : 64;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Append the expected bits of one character to expv/en.
    task automatic add_char(input logic [7:0] d, input int len, input bit pe,
                            input bit po, input int stops, input bit framed);
        int ones = 0;
        if (framed) begin expv[en] = 1'b0; en++; end
        for (int i = 0; i < len; i++) begin
            expv[en] = d[i]; ones += int'(d[i]); en++;
        end
        if (pe) begin expv[en] = po ? ~ones[0] : ones[0]; en++; end
        for (int i = 0; i < stops; i++) begin expv[en] = 1'b1; en++; end
    endtask

    // One fall pulse; returns 1 when this pulse starts a new bit time.
    task automatic pulse(output bit is_tick);
        @(negedge clk);
        txclk_fall = 1'b1;
        @(negedge clk);
        txclk_fall = 1'b0;
        pcount++;
        is_tick = (pcount % fac) == 0;
    endtask

    task automatic collect_cmp(input int nbits, input string req);
        bit   tk;
        bit   steady = 1;
        int   bad_at = -1;
        logic last = txd;
        for (int b = 0; b < nbits; b++) begin
            tk = 0;
            while (!tk) begin
                pulse(tk);
                if (!tk && txd !== last) steady = 0;
            end
            if (txd !== expv[b] && bad_at < 0) bad_at = b;
            last = txd;
        end
        chk(bad_at < 0, req, "serial bit stream (first bad bit index)",
            bad_at, -1);
        chk(steady, "R3", "txd moved between bit times", 0, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_rdy === 1'b1, "R1", "tx_rdy after reset", int'(tx_rdy), 1);
        chk(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    endtask

    task automatic t_async_x1();
        do_reset();
        cfg_async(2'b00, 8, 0, 0, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA5;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_rdy === 1'b0, "R4", "tx_rdy after first edge", int'(tx_rdy), 0);
        @(negedge clk);
        chk(tx_rdy === 1'b1, "R4", "tx_rdy after transfer", int'(tx_rdy), 1);
        chk(tx_empty === 1'b0, "R7", "tx_empty while shifting", int'(tx_empty), 0);
        en = 0; expv = '1;
        add_char(8'hA5, 8, 0, 0, 1, 1);
        collect_cmp(en, "R2");
        chk(tx_empty === 1'b1, "R7", "tx_empty after last bit", int'(tx_empty), 1);
    endtask

    task automatic t_async_x16();
        do_reset();
        cfg_async(2'b01, 7, 1, 0, 1);
        write(8'h5A);
        @(negedge clk);
        en = 0; expv = '1;
        add_char(8'h5A, 7, 1, 0, 2, 1);
        collect_cmp(en, "R2");
    endtask

    task automatic t_async_x64();
        do_reset();
        cfg_async(2'b10, 5, 1, 1, 0);
        write(8'h13);
        @(negedge clk);
        en = 0; expv = '1;
        add_char(8'h13, 5, 1, 1, 1, 1);
        collect_cmp(en, "R3");
    endtask

    task automatic t_overwrite();
        do_reset();
        cfg_async(2'b00, 8, 0, 0, 0);
        write(8'h11);
        @(negedge clk);
        write(8'h22);
        chk(tx_rdy === 1'b0, "R5", "tx_rdy with buffer full", int'(tx_rdy), 0);
        write(8'h33);
        chk(tx_rdy === 1'b0, "R5", "tx_rdy after overwrite", int'(tx_rdy), 0);
        en = 0; expv = '1;
        add_char(8'h11, 8, 0, 0, 1, 1);
        add_char(8'h33, 8, 0, 0, 1, 1);
        collect_cmp(en, "R6");
        chk(tx_empty === 1'b1, "R5", "tx_empty after both frames", int'(tx_empty), 1);
    endtask

    task automatic t_sync();
        do_reset();
        tx_en = 1'b0;
        cfg_sync = 1'b1; cfg_len = 2'd3; cfg_par_en = 1'b0; fac = 1;
        cfg_sync_char = 8'h16;
        write(8'h3C);
        @(negedge clk);
        chk(tx_rdy === 1'b0, "R9", "tx_rdy while disabled", int'(tx_rdy), 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_rdy === 1'b1, "R8", "tx_rdy after enable", int'(tx_rdy), 1);
        en = 0; expv = '1;
        add_char(8'h3C, 8, 0, 0, 0, 0);
        add_char(8'h16, 8, 0, 0, 0, 0);
        add_char(8'h16, 8, 0, 0, 0, 0);
        collect_cmp(en, "R8");
        chk(tx_empty === 1'b1, "R8", "tx_empty during sync fill", int'(tx_empty), 1);
        cfg_sync = 1'b0;
    endtask

    task automatic t_cts();
        bit tk;
        bit marks = 1;
        do_reset();
        cfg_async(2'b00, 8, 0, 0, 0);
        write(8'hC3);
        @(negedge clk);
        en = 0; expv = '1;
        add_char(8'hC3, 8, 0, 0, 1, 1);
        for (int b = 0; b < 3; b++) pulse(tk);
        cts_n = 1'b1;
        for (int b = 3; b < 10; b++) begin
            pulse(tk);
            if (txd !== expv[b]) marks = 0;
        end
        chk(marks, "R9", "frame completes after clear-to-send drop", 0, 1);
        write(8'h81);
        @(negedge clk);
        chk(tx_rdy === 1'b0, "R9", "no transfer while disabled", int'(tx_rdy), 0);
        chk(tx_empty === 1'b0, "R7", "tx_empty with char waiting", int'(tx_empty), 0);
        marks = 1;
        for (int b = 0; b < 4; b++) begin
            pulse(tk);
            if (txd !== 1'b1) marks = 0;
        end
        chk(marks, "R9", "line idles high while disabled", 0, 1);
        cts_n = 1'b0;
        @(negedge clk);
        en = 0; expv = '1;
        add_char(8'h81, 8, 0, 0, 1, 1);
        collect_cmp(en, "R9");
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_async_x1();
        t_async_x16();
        t_async_x64();
        t_overwrite();
        t_sync();
        t_cts();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule